// File: doc/BRIEF.md
# Network adapter command/status register front end

This block is the register set that a processor sees when it drives a simple network adapter. It holds three 16-bit registers: a control/status word, a buffer byte address and a buffer byte count. Software writes the address and count first. It then writes the control/status word, and that single write carries the function code, the two top buffer address bits and both interrupt enables. The block checks the command's arguments against the adapter state. If the arguments are bad, the command completes in the same cycle as the write with an error code. Otherwise the command goes to an execution stub that takes a fixed number of cycles. Completion sets a done flag and a 4-bit outcome code, and raises the command interrupt when that interrupt is enabled.

A second path runs alongside the command path. It reports that a received frame has landed in a buffer. The block takes the two error flags and the length field from the frame header, and removes the four trailing check bytes from the length. It then sets a receive-done flag and raises the receive interrupt when that interrupt is enabled. For testing, the execution stub can replace the normal outcome of a command with a chosen code.

Top module: `nic_csr_front`

## Requirements
- R1: After reset, all three registers read 0. Both interrupt outputs, the busy output and the online output are 0.
- R2: A write to the address register (select 1) or to the count register (select 2) reads back unchanged. Such a write is accepted even while a command is busy. A control/status write that is accepted latches the 18-bit buffer address. Bits 17:16 come from bits 15:14 of the written word and bits 15:0 come from the address register.
- R3: Control/status (select 0) has this layout: bits 3:0 hold the status, bit 4 is receive interrupt enable, bit 5 is receive done, bit 6 is command interrupt enable, bit 7 is command done, bits 13:8 hold the function and bits 15:14 hold the high address. The legal functions, in octal, are: go online 011, clear source-address insertion 016, statistics 030, receive 040, send 051 and reset 077. A legal command whose arguments pass the checks sets busy and clears done in the cycle after the write. It stays busy for LATENCY cycles, then shows done with status 0, and busy and done are never both 1.
- R4: A function code outside the legal set completes in the cycle after the write with done set and status 2. This check takes priority over every other check.
- R5: A send or statistics command issued while offline completes at once with status 3. This check takes priority over the alignment and size checks. After go online completes, the online output is 1.
- R6: A send or receive command issued with an odd address register completes at once with status 10. This check takes priority over the size check.
- R7: A send command whose count is below MIN_FRAME (60) completes at once with status 6. A count of exactly 60 is accepted.
- R8: The command interrupt is 1 exactly while command done and command interrupt enable are both 1.
- R9: A control/status write that arrives while busy is ignored. The function, the enables and receive done keep their values, and the running command completes normally.
- R10: A landed-frame pulse sets receive done. The receive interrupt is 1 while receive done and receive enable are both 1. An accepted control/status write with bit 5 set clears receive done, and a write with bit 5 clear leaves it unchanged.
- R11: On a landed frame, the error output is 1 when either of the two header flag bits is 1. The length output is the header length minus 4, and it is 0 when the header length is below 4.
- R12: The reset command clears online, receive done and both enables when it completes, and it finishes with status 0 and done set.
- R13: When inject is high in the cycle an executing command finishes, the status becomes the inject code and the go-online and reset side effects are skipped. Commands that complete at once are not affected by inject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select: 0 control/status, 1 address, 2 count |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (0 for select 3) |
| inj_en | input | 1 | Replace the outcome of the finishing command |
| inj_code | input | 4 | Outcome code used when injecting |
| rx_land | input | 1 | One-cycle pulse: a frame has landed in a buffer |
| rx_flags | input | 2 | Low two bits of the header status byte |
| rx_hdr_len | input | 16 | Header length field, check bytes included |
| cmd_busy | output | 1 | A command is executing |
| cmd_irq | output | 1 | Command interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| online | output | 1 | Adapter is online |
| buf_addr | output | 18 | Buffer address latched at command start |
| rx_err | output | 1 | Last landed frame had an error flag |
| rx_len | output | 16 | Payload length of the last landed frame |

## Verification
The command path is driven with legal and illegal function codes, and with argument combinations that break more than one check at the same time. An odd address while offline, for example, shows whether the checks are applied in the stated priority order. Counts of 59 and 60 locate the edge of the minimum-frame rule. Executing commands are sampled one cycle before and in the cycle of the LATENCY boundary, which exposes an off-by-one in the stub. Writes are issued while busy, frames land with and without error flags and with lengths below 4, and injected outcomes are applied to both executing and immediately completing commands. Together these separate the ignore, header-parse and inject rules from the ordinary completion path.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

    localparam logic [1:0] SEL_CSR = 2'd0;
    localparam logic [1:0] SEL_BAR = 2'd1;
    localparam logic [1:0] SEL_BCR = 2'd2;

    localparam logic [5:0] FN_ONLINE = 6'o11;
    localparam logic [5:0] FN_NOSRC  = 6'o16;
    localparam logic [5:0] FN_STATS  = 6'o30;
    localparam logic [5:0] FN_RECV   = 6'o40;
    localparam logic [5:0] FN_XMIT   = 6'o51;
    localparam logic [5:0] FN_RESET  = 6'o77;

    localparam logic [3:0] ST_OK      = 4'd0;
    localparam logic [3:0] ST_RETRY   = 4'd1;
    localparam logic [3:0] ST_ILLEGAL = 4'd2;
    localparam logic [3:0] ST_INAPP   = 4'd3;
    localparam logic [3:0] ST_FAIL    = 4'd4;
    localparam logic [3:0] ST_TOOBIG  = 4'd5;
    localparam logic [3:0] ST_SHORT   = 4'd6;
    localparam logic [3:0] ST_COLL    = 4'd8;
    localparam logic [3:0] ST_ALIGN   = 4'd10;
    localparam logic [3:0] ST_NOMEM   = 4'd15;

    typedef struct packed {
        logic [1:0] hadd;
        logic [5:0] fn;
        logic       cdone;
        logic       cie;
        logic       rdone;
        logic       rie;
        logic [3:0] stat;
    } csr_t;

    typedef struct packed {
        csr_t        csr;
        logic [15:0] bar;
        logic [15:0] bcr;
        logic        online;
        logic [17:0] bufadr;
        logic        rx_err;
        logic [15:0] rx_len;
    } front_state_t;

endpackage

// File: rtl/nic_cmd_check.sv
module nic_cmd_check
    import nic_csr_pkg::*;
#(
    parameter int MIN_FRAME = 60
) (
    input  logic [5:0]  fn,
    input  logic        is_online,
    input  logic        addr_odd,
    input  logic [15:0] count,
    output logic        imm_fail,
    output logic [3:0]  imm_code
);
    logic legal;
    logic needs_link;
    logic moves_data;

    always_comb begin
        legal      = (fn == FN_ONLINE) || (fn == FN_NOSRC) || (fn == FN_STATS) ||
                     (fn == FN_RECV)   || (fn == FN_XMIT)  || (fn == FN_RESET);
        needs_link = (fn == FN_XMIT) || (fn == FN_STATS);
        moves_data = (fn == FN_XMIT) || (fn == FN_RECV);
        imm_fail   = 1'b1;
        imm_code   = ST_OK;
        if (!legal) begin
            imm_code = ST_ILLEGAL;
        end else if (needs_link && !is_online) begin
            imm_code = ST_INAPP;
        end else if (moves_data && addr_odd) begin
            imm_code = ST_ALIGN;
        end else if ((fn == FN_XMIT) && (count < 16'(MIN_FRAME))) begin
            imm_code = ST_SHORT;
        end else begin
            imm_fail = 1'b0;
        end
    end
endmodule

// File: rtl/nic_exec_stub.sv
module nic_exec_stub #(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic finish
);
    localparam int CW = $clog2(LATENCY + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(LATENCY);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy   = (cnt_q != '0);
    assign finish = (cnt_q == CW'(1));
endmodule

// File: rtl/nic_rx_hdr.sv
module nic_rx_hdr #(
    parameter int CHECK_BYTES = 4
) (
    input  logic [1:0]  flags,
    input  logic [15:0] hdr_len,
    output logic        err,
    output logic [15:0] payload_len
);
    assign err         = |flags;
    assign payload_len = (hdr_len >= 16'(CHECK_BYTES)) ? hdr_len - 16'(CHECK_BYTES) : 16'd0;
endmodule

// File: rtl/nic_csr_front.sv
module nic_csr_front
    import nic_csr_pkg::*;
#(
    parameter int LATENCY   = 4,
    parameter int MIN_FRAME = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_sel,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        inj_en,
    input  logic [3:0]  inj_code,
    input  logic        rx_land,
    input  logic [1:0]  rx_flags,
    input  logic [15:0] rx_hdr_len,
    output logic        cmd_busy,
    output logic        cmd_irq,
    output logic        rx_irq,
    output logic        online,
    output logic [17:0] buf_addr,
    output logic        rx_err,
    output logic [15:0] rx_len
);
    front_state_t state_d, state_q;

    logic        csr_accept;
    logic        imm_fail;
    logic [3:0]  imm_code;
    logic        exec_start;
    logic        exec_busy;
    logic        exec_finish;
    logic        hdr_err;
    logic [15:0] hdr_payload;
    logic [15:0] csr_view;
    logic [15:0] bar_view;
    logic [15:0] bcr_view;

    assign csr_accept = bus_wr && (bus_sel == SEL_CSR) && !exec_busy;
    assign exec_start = csr_accept && !imm_fail;

    nic_cmd_check #(.MIN_FRAME(MIN_FRAME)) u_check (
        .fn        (bus_wdata[13:8]),
        .is_online (state_q.online),
        .addr_odd  (state_q.bar[0]),
        .count     (state_q.bcr),
        .imm_fail  (imm_fail),
        .imm_code  (imm_code)
    );

    nic_exec_stub #(.LATENCY(LATENCY)) u_stub (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (exec_start),
        .busy   (exec_busy),
        .finish (exec_finish)
    );

    nic_rx_hdr #(.CHECK_BYTES(4)) u_rxhdr (
        .flags       (rx_flags),
        .hdr_len     (rx_hdr_len),
        .err         (hdr_err),
        .payload_len (hdr_payload)
    );

    always_comb begin
        state_d = state_q;

        if (bus_wr && (bus_sel == SEL_BAR)) state_d.bar = bus_wdata;
        if (bus_wr && (bus_sel == SEL_BCR)) state_d.bcr = bus_wdata;

        if (csr_accept) begin
            state_d.csr.hadd = bus_wdata[15:14];
            state_d.csr.fn   = bus_wdata[13:8];
            state_d.csr.cie  = bus_wdata[6];
            state_d.csr.rie  = bus_wdata[4];
            if (bus_wdata[5]) state_d.csr.rdone = 1'b0;
            state_d.bufadr   = {bus_wdata[15:14], state_q.bar};
            if (imm_fail) begin
                state_d.csr.cdone = 1'b1;
                state_d.csr.stat  = imm_code;
            end else begin
                state_d.csr.cdone = 1'b0;
                state_d.csr.stat  = ST_OK;
            end
        end

        if (exec_finish) begin
            state_d.csr.cdone = 1'b1;
            if (inj_en) begin
                state_d.csr.stat = inj_code;
            end else begin
                state_d.csr.stat = ST_OK;
                if (state_q.csr.fn == FN_ONLINE) begin
                    state_d.online = 1'b1;
                end else if (state_q.csr.fn == FN_RESET) begin
                    state_d.online    = 1'b0;
                    state_d.csr.rdone = 1'b0;
                    state_d.csr.cie   = 1'b0;
                    state_d.csr.rie   = 1'b0;
                end
            end
        end

        if (rx_land) begin
            state_d.csr.rdone = 1'b1;
            state_d.rx_err    = hdr_err;
            state_d.rx_len    = hdr_payload;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign csr_view = state_q.csr;
    assign bar_view = state_q.bar;
    assign bcr_view = state_q.bcr;

    always_comb begin
        case (bus_sel)
            SEL_CSR: bus_rdata = csr_view;
            SEL_BAR: bus_rdata = bar_view;
            SEL_BCR: bus_rdata = bcr_view;
            default: bus_rdata = 16'h0000;
        endcase
    end

    assign cmd_busy = exec_busy;
    assign cmd_irq  = state_q.csr.cdone && state_q.csr.cie;
    assign rx_irq   = state_q.csr.rdone && state_q.csr.rie;
    assign online   = state_q.online;
    assign buf_addr = state_q.bufadr;
    assign rx_err   = state_q.rx_err;
    assign rx_len   = state_q.rx_len;
endmodule

// File: rtl/nic_csr_sva.sv
module nic_csr_sva #(
    parameter int MIN_FRAME = 60
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [1:0]  bus_sel,
    input logic [15:0] bus_wdata,
    input logic        cmd_busy,
    input logic        cmd_irq,
    input logic        online,
    input logic        rx_land,
    input logic [15:0] csr_view,
    input logic [15:0] bar_view,
    input logic [15:0] bcr_view
);
    logic       csr_wr;
    logic       accepted;
    logic [5:0] wfn;
    logic       wfn_legal;

    assign csr_wr    = bus_wr && (bus_sel == 2'd0);
    assign accepted  = csr_wr && !cmd_busy;
    assign wfn       = bus_wdata[13:8];
    assign wfn_legal = (wfn == 6'o11) || (wfn == 6'o16) || (wfn == 6'o30) ||
                       (wfn == 6'o40) || (wfn == 6'o51) || (wfn == 6'o77);

    // R3: busy and done are exclusive
    assert_busy_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |-> !csr_view[7]);

    // R3: end of execution leaves done set
    assert_busy_end_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_busy) |-> csr_view[7]);

    // R4: unknown function completes at once with status 2
    assert_illegal_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && !wfn_legal) |=> (csr_view[7] && csr_view[3:0] == 4'd2));

    // R5: send while offline is inappropriate
    assert_offline_send_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && wfn == 6'o51 && !online) |=> (csr_view[3:0] == 4'd3));

    // R7: short send frame
    assert_short_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && wfn == 6'o51 && online && !bar_view[0] && bcr_view < 16'(MIN_FRAME))
        |=> (csr_view[7] && csr_view[3:0] == 4'd6));

    // R8: command interrupt only with done and enable
    assert_cmd_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq |-> (csr_view[7] && csr_view[6]));

    // R9: busy writes leave the function unchanged
    assert_busy_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && cmd_busy) |=> $stable(csr_view[13:8]));

    // R10: landed frame sets receive done
    assert_rx_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_land |=> csr_view[5]);
endmodule

bind nic_csr_front nic_csr_sva #(.MIN_FRAME(MIN_FRAME)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .cmd_busy  (cmd_busy),
    .cmd_irq   (cmd_irq),
    .online    (online),
    .rx_land   (rx_land),
    .csr_view  (csr_view),
    .bar_view  (bar_view),
    .bcr_view  (bcr_view)
);

// File: tb/nic_csr_front_tb_top.sv
`timescale 1ns/1ps
module nic_csr_front_tb_top;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        inj_en = 1'b0;
    logic [3:0]  inj_code = 4'd0;
    logic        rx_land = 1'b0;
    logic [1:0]  rx_flags = 2'd0;
    logic [15:0] rx_hdr_len = 16'd0;
    logic        cmd_busy, cmd_irq, rx_irq, online, rx_err;
    logic [17:0] buf_addr;
    logic [15:0] rx_len;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    nic_csr_front #(.LATENCY(LAT), .MIN_FRAME(60)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .inj_en(inj_en),
        .inj_code(inj_code), .rx_land(rx_land), .rx_flags(rx_flags),
        .rx_hdr_len(rx_hdr_len), .cmd_busy(cmd_busy), .cmd_irq(cmd_irq),
        .rx_irq(rx_irq), .online(online), .buf_addr(buf_addr),
        .rx_err(rx_err), .rx_len(rx_len)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] val);
        bus_sel = sel;
        #1;
        val = bus_rdata;
    endtask

    task automatic land(input logic [1:0] fl, input logic [15:0] len);
        @(negedge clk);
        rx_land = 1'b1; rx_flags = fl; rx_hdr_len = len;
        @(negedge clk);
        rx_land = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(2'd0, v); chk("R1", "csr after reset", v, 0);
        rd(2'd1, v); chk("R1", "bar after reset", v, 0);
        rd(2'd2, v); chk("R1", "bcr after reset", v, 0);
        chk("R1", "irqs busy online", {cmd_irq, rx_irq, cmd_busy, online}, 0);
    endtask

    task automatic t_regs;
        logic [15:0] v;
        wr(2'd1, 16'h1233); wr(2'd2, 16'h0100);
        rd(2'd1, v); chk("R2", "bar readback", v, 16'h1233);
        rd(2'd2, v); chk("R2", "bcr readback", v, 16'h0100);
    endtask

    task automatic t_offline;
        logic [15:0] v;
        wr(2'd0, 16'h2940);
        rd(2'd0, v); chk("R5", "send offline odd bar status", v[3:0], 3);
        chk("R5", "send offline done", v[7], 1);
        chk("R8", "irq with cie", cmd_irq, 1);
        wr(2'd0, 16'h1800);
        rd(2'd0, v); chk("R5", "stats offline status", v[3:0], 3);
        chk("R8", "no irq without cie", cmd_irq, 0);
    endtask

    task automatic t_illegal;
        logic [15:0] v;
        wr(2'd0, 16'h0540);
        rd(2'd0, v); chk("R4", "illegal fn status", v[3:0], 2);
        chk("R4", "illegal fn done not busy", {v[7], cmd_busy}, 2'b10);
    endtask

    task automatic t_online;
        logic [15:0] v;
        wr(2'd0, 16'h0940);
        rd(2'd0, v); chk("R3", "busy done after start", {cmd_busy, v[7]}, 2'b10);
        chk("R8", "no irq while busy", cmd_irq, 0);
        wait_cyc(LAT - 1);
        rd(2'd0, v); chk("R3", "still busy at LAT-1", {cmd_busy, v[7]}, 2'b10);
        wait_cyc(1);
        rd(2'd0, v); chk("R3", "done at LAT", {cmd_busy, v[7], v[3:0]}, 6'b01_0000);
        chk("R5", "online after go online", online, 1);
        chk("R8", "irq on completion", cmd_irq, 1);
    endtask

    task automatic t_align;
        logic [15:0] v;
        wr(2'd0, 16'h2900);
        rd(2'd0, v); chk("R6", "send odd bar", v[3:0], 10);
        wr(2'd2, 16'd59);
        wr(2'd0, 16'h2000);
        rd(2'd0, v); chk("R6", "recv odd bar", v[3:0], 10);
        wr(2'd0, 16'h2900);
        rd(2'd0, v); chk("R6", "align before size", v[3:0], 10);
    endtask

    task automatic t_short;
        logic [15:0] v;
        wr(2'd1, 16'h1000);
        wr(2'd0, 16'h2900);
        rd(2'd0, v); chk("R7", "send count 59", v[3:0], 6);
        wr(2'd2, 16'd60);
        wr(2'd0, 16'hA900);
        chk("R7", "send count 60 executes", cmd_busy, 1);
        chk("R2", "buffer address", buf_addr, 18'h21000);
        wait_cyc(LAT);
        rd(2'd0, v); chk("R7", "send 60 status", {v[7], v[3:0]}, 5'b1_0000);
    endtask

    task automatic t_busy_ignore;
        logic [15:0] v;
        wr(2'd0, 16'h2000);
        wr(2'd0, 16'h3F70);
        rd(2'd0, v); chk("R9", "fn and enables kept", {v[13:8], v[6], v[4]}, {6'o40, 2'b00});
        wait_cyc(LAT - 3);
        chk("R9", "still busy", cmd_busy, 1);
        wait_cyc(1);
        rd(2'd0, v); chk("R9", "recv completes normally", {v[7], v[3:0]}, 5'b1_0000);
        chk("R9", "not reset by ignored write", online, 1);
    endtask

    task automatic t_rx;
        logic [15:0] v;
        wr(2'd0, 16'h0E10);
        wait_cyc(LAT);
        land(2'b10, 16'd100);
        rd(2'd0, v); chk("R10", "rx done set", v[5], 1);
        chk("R10", "rx irq", rx_irq, 1);
        chk("R11", "err and len", {rx_err, rx_len}, {1'b1, 16'd96});
        land(2'b00, 16'd3);
        chk("R11", "short header len", {rx_err, rx_len}, {1'b0, 16'd0});
        wr(2'd0, 16'h0510);
        rd(2'd0, v); chk("R10", "bit5 clear keeps rx done", v[5], 1);
        wr(2'd0, 16'h0530);
        rd(2'd0, v); chk("R10", "bit5 set clears rx done", {v[5], rx_irq}, 2'b00);
        land(2'b01, 16'd64);
        chk("R11", "flag bit0 error", {rx_err, rx_len}, {1'b1, 16'd60});
    endtask

    task automatic t_inject;
        logic [15:0] v;
        inj_en = 1'b1; inj_code = 4'd8;
        wr(2'd0, 16'h1800);
        wait_cyc(LAT);
        rd(2'd0, v); chk("R13", "injected stats status", {v[7], v[3:0]}, 5'b1_1000);
        wr(2'd0, 16'h0500);
        rd(2'd0, v); chk("R13", "immediate not injected", v[3:0], 2);
        inj_en = 1'b0;
    endtask

    task automatic t_reset_cmd;
        logic [15:0] v;
        wr(2'd0, 16'h3F50);
        wait_cyc(LAT);
        rd(2'd0, v); chk("R12", "csr after reset cmd", v, 16'h3F80);
        chk("R12", "offline and no rx irq", {online, rx_irq}, 2'b00);
        inj_en = 1'b1; inj_code = 4'd4;
        wr(2'd0, 16'h0900);
        wait_cyc(LAT);
        rd(2'd0, v); chk("R13", "injected online status", v[3:0], 4);
        chk("R13", "online skipped on inject", online, 0);
        inj_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_offline();
        t_illegal();
        t_online();
        t_align();
        t_short();
        t_busy_ignore();
        t_rx();
        t_inject();
        t_reset_cmd();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule